// File: doc/BRIEF.md
# Eager Token Fork with Per-Consumer Completion Flags

This block copies one valid/ready token stream to several consumers. Every consumer receives each input token exactly once. The input is released only after every consumer has taken the current token. The consumers need not take it in the same cycle: a flag per consumer records that its copy has been delivered. Once its flag is set, that consumer's valid is withheld until the next token.

An output's valid never looks at that output's ready. A consumer that waits for valid before raising ready therefore cannot deadlock the fork. A typical use is the read side of a memory load port, where one output carries the read data and another signals that the access is complete.

The payload passes combinationally to all outputs. The block holds no data register, only one delivery flag per output.

Top module: `eager_fork`

## Requirements
- R1: After reset is released, no output is marked as served: the first input token raises every output valid together.
- R2: Output i's valid is high exactly when the input valid is high and output i has not yet taken the current token. It does not depend on any ready, so a consumer that waits for valid before asserting ready still makes progress.
- R3: A consumer is never handed the same token twice. After output i completes a handshake while the input is still held, `out_valid_o[i]` is low until the input token is accepted.
- R4: `in_ready_o` is high only when every output has either already taken the current token or is completing its handshake in that same cycle. `in_ready_o` is never high while `in_valid_i` is low.
- R5: When all outputs are ready in the same cycle, the input token is accepted in that single cycle.
- R6: Every output's data (`out_data_o[i]`) equals `in_data_i` in the same cycle, with no register in the path.
- R7: In the cycle after the input is accepted, all delivery flags are clear. A new input token raises every output valid at once.
- R8: While `in_valid_i` is low, every bit of `out_valid_o` is low.
- R9: `NUM_OUT` must be at least 2. A smaller value stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, clears all delivery flags |
| in_valid_i | input | 1 | Input token present |
| in_ready_o | output | 1 | Input token released this cycle |
| in_data_i | input | DATA_W | Input payload |
| out_valid_o | output | NUM_OUT | Per-output valid, bit i for output i |
| out_ready_i | input | NUM_OUT | Per-output ready, bit i for output i |
| out_data_o | output | NUM_OUT x DATA_W | Per-output payload, element i for output i |

## Verification
Valid, data and input ready are combinational, so their values are due in the same cycle as the stimulus. The bench samples them on the falling edge after it drives inputs just past the rising edge. A flag change is due one rising edge after the handshake that sets or clears it, and is checked on the next falling edge. A scoreboard keeps one queue per output. It pops an item on each handshake it sees and flags a handshake that finds its queue empty. This catches both a duplicate delivery and a wrong payload, and at the end it checks that every queue has drained.

// File: rtl/fork_pkg.sv
package fork_pkg;
  localparam int unsigned MinOutputs = 2;

  function automatic logic all_set(input logic [31:0] v, input int unsigned n);
    logic r;
    r = 1'b1;
    for (int unsigned k = 0; k < 32; k++)
      if (k < n) r = r & v[k];
    return r;
  endfunction
endpackage

// File: rtl/fork_lane.sv
// One consumer slot: tracks whether the current token was delivered here.
module fork_lane (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tok_valid_i,
  input  logic tok_accept_i,
  input  logic ready_i,
  output logic valid_o,
  output logic done_o
);
  logic sent_q;
  logic fire;

  assign valid_o = tok_valid_i & ~sent_q;
  assign fire    = valid_o & ready_i;
  assign done_o  = sent_q | fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           sent_q <= 1'b0;
    else if (tok_accept_i) sent_q <= 1'b0;
    else if (fire)         sent_q <= 1'b1;
  end
endmodule

// File: rtl/fork_join.sv
// Releases the input once every lane reports done.
module fork_join #(
  parameter int unsigned NUM_OUT = 2
) (
  input  logic               tok_valid_i,
  input  logic [NUM_OUT-1:0] done_i,
  output logic               release_o
);
  assign release_o = tok_valid_i & (&done_i);
endmodule

// File: rtl/eager_fork.sv
module eager_fork #(
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned DATA_W  = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           in_valid_i,
  output logic                           in_ready_o,
  input  logic [DATA_W-1:0]              in_data_i,
  output logic [NUM_OUT-1:0]             out_valid_o,
  input  logic [NUM_OUT-1:0]             out_ready_i,
  output logic [NUM_OUT-1:0][DATA_W-1:0] out_data_o
);
  import fork_pkg::*;

  // R9
  if (NUM_OUT < MinOutputs) begin : g_bad_cfg
    $error("eager_fork: NUM_OUT must be at least 2");
  end

  logic [NUM_OUT-1:0] lane_done;
  logic               accept;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    fork_lane u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tok_valid_i (in_valid_i),
      .tok_accept_i(accept),
      .ready_i     (out_ready_i[i]),
      .valid_o     (out_valid_o[i]),
      .done_o      (lane_done[i])
    );
    assign out_data_o[i] = in_data_i;
  end

  fork_join #(.NUM_OUT(NUM_OUT)) u_join (
    .tok_valid_i(in_valid_i),
    .done_i     (lane_done),
    .release_o  (accept)
  );

  assign in_ready_o = accept;
endmodule

// File: rtl/eager_fork_chk.sv
module eager_fork_chk #(
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned DATA_W  = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           in_valid_i,
  input logic                           in_ready_o,
  input logic [DATA_W-1:0]              in_data_i,
  input logic [NUM_OUT-1:0]             out_valid_o,
  input logic [NUM_OUT-1:0]             out_ready_i,
  input logic [NUM_OUT-1:0][DATA_W-1:0] out_data_o
);
  // R8
  idle_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> (out_valid_o == '0));

  // R4
  ready_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> in_valid_i);

  // R7
  flags_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (!in_valid_i || (&out_valid_o)));

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    // R3
    no_dup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[i] && out_ready_i[i] && !in_ready_o) |=> !out_valid_o[i]);

    // R4
    ready_all_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_ready_o && out_valid_o[i]) |-> out_ready_i[i]);

    // R6
    data_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[i] |-> (out_data_o[i] == in_data_i));
  end
endmodule

bind eager_fork eager_fork_chk #(.NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_eager_fork.sv
`timescale 1ns/1ps
module sim_eager_fork;
  localparam int unsigned N = 3;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [W-1:0] in_data = '0;
  logic [N-1:0] out_valid;
  logic [N-1:0] out_ready;
  logic [N-1:0][W-1:0] out_data;

  logic [N-1:0] man_ready = '0;
  logic [N-1:0] rmask = '0;
  logic rnd_mode = 1'b0;

  int total = 0;
  int bad = 0;
  int pops = 0;
  int pushes = 0;
  logic [W-1:0] exp_q [N][$];

  always #10 clk = ~clk;

  // random mode: consumers wait for valid before raising ready
  always_comb out_ready = rnd_mode ? (out_valid & rmask) : man_ready;

  eager_fork #(.NUM_OUT(N), .DATA_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_tok(input logic [W-1:0] d);
    in_valid = 1'b1;
    in_data  = d;
    pushes++;
    for (int i = 0; i < N; i++) exp_q[i].push_back(d);
  endtask

  // monitor: one pop per handshake, R3 duplicate and R6 data
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (out_valid[i] && out_ready[i]) begin
          if (exp_q[i].size() == 0) begin
            chk("R3 extra delivery", 32'd1, 32'd0);
          end else begin
            chk("R6 scoreboard data", 32'(out_data[i]), 32'(exp_q[i].pop_front()));
            pops++;
          end
        end
      end
    end
  end

  task automatic send(input logic [W-1:0] d);
    push_tok(d);
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk("R8 reset out_valid", 32'(out_valid), 32'd0);
    chk("R4 reset in_ready", 32'(in_ready), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1/R2: token with no ready, valids all high, held
    @(posedge clk); #1 push_tok(8'hA5);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R1 R2 all valid without ready", 32'(out_valid), 32'h7);
      chk("R4 no release", 32'(in_ready), 32'd0);
    end
    chk("R6 data lane2", 32'(out_data[2]), 32'hA5);

    @(posedge clk); #1 man_ready = 3'b001;
    @(negedge clk);
    chk("R4 partial", 32'(in_ready), 32'd0);
    @(posedge clk); #1 man_ready = 3'b000;
    @(negedge clk);
    chk("R3 lane0 withheld", 32'(out_valid), 32'h6);
    @(posedge clk); #1 man_ready = 3'b011;
    @(negedge clk);
    chk("R3 lane0 still low", 32'(out_valid), 32'h6);
    chk("R4 lane2 pending", 32'(in_ready), 32'd0);
    @(posedge clk); #1 man_ready = 3'b100;
    @(negedge clk);
    chk("R4 last lane completes", 32'(in_ready), 32'd1);
    @(posedge clk); #1 man_ready = 3'b000; push_tok(8'h3C);
    @(negedge clk);
    chk("R7 flags cleared", 32'(out_valid), 32'h7);
    chk("R6 new data", 32'(out_data[0]), 32'h3C);
    @(posedge clk); #1 man_ready = 3'b111;
    @(negedge clk);
    chk("R5 single-cycle accept", 32'(in_ready), 32'd1);
    @(posedge clk); #1 man_ready = 3'b000; in_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle", 32'(out_valid), 32'd0);

    // R2: consumers gate ready on valid, random masks
    rnd_mode = 1'b1;
    fork
      begin
        for (int k = 0; k < 300; k++) send(W'($urandom));
      end
      begin
        for (int k = 0; k < 3000; k++) begin
          @(posedge clk); #1 rmask = N'($urandom);
        end
      end
    join_any
    disable fork;
    rnd_mode = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < N; i++)
      chk("R3 queue drained", 32'(exp_q[i].size()), 32'd0);
    chk("R3 exactly once", 32'(pops), 32'(pushes * N));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule